// File: doc/BRIEF.md
# Stream-Handshaked Greatest Common Divisor Unit

This block computes the greatest common divisor of two unsigned operands, 16 bits each by default. A request is one packed word that carries both operands. The 16-bit result leaves as a response word. Both sides use a valid/ready stream handshake: a word moves on a cycle where valid and ready are both high.

A two-entry queue sits on each side, so the arithmetic core is decoupled from both neighbours. The core handles one operand pair at a time. Each cycle it either swaps the operands, when the first is smaller, or subtracts the second from the first. It finishes once the second operand is zero, so latency depends on the data.

The core starts a new operation only when the result queue has room. A finished result is held in the core until the result queue accepts it. Responses therefore leave in request order, with none lost and none repeated, whatever stalls either neighbour applies.

Top module: `gcd_stream_unit`

## Requirements
- R1: For a request word with operand A in bits [31:16] and operand B in bits [15:0], the response word `out_data_o` equals gcd(A, B).
- R2: Zero operands finish without hanging: gcd(0, x) = x, gcd(x, 0) = x, and gcd(0, 0) = 0.
- R3: A word is transferred only on a cycle where its valid and ready are both high. `in_ready_o` is low exactly when the request queue holds two entries. `out_valid_o` is high exactly when the result queue holds at least one entry.
- R4: No request leaves the request queue while the result queue is full. With `out_ready_i` held low, the unit therefore accepts exactly four spaced requests (two results queued and two requests waiting), and `in_ready_o` is then low.
- R5: Responses leave in request order, with no drop and no duplicate, under arbitrary stalls on both sides.
- R6: On an idle unit with `out_ready_i` high, the result of gcd(x, 0) makes `out_valid_o` high after the third rising edge that follows the accepting edge, and not after the second. The result of gcd(0, x) is due one edge later, because of the one swap step.
- R7: While `out_valid_o` is high and `out_ready_i` is low, `out_valid_o` stays high and `out_data_o` stays unchanged.
- R8: An asynchronous reset, active low on `rst_ni`, empties both queues and puts the core in its idle state. During and after reset, `in_ready_o` is 1 and `out_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_data_i | input | 32 | Request word: operand A in [31:16], operand B in [15:0] |
| in_valid_i | input | 1 | Request word valid |
| in_ready_o | output | 1 | Request queue can take a word |
| out_data_o | output | 16 | GCD result word |
| out_valid_o | output | 1 | Result queue holds a word |
| out_ready_i | input | 1 | Consumer takes the result word |

## Verification
On an idle unit, a result with B equal to zero is due at `out_valid_o` three edges after its request is accepted. A swap adds one edge, and every other step of the algorithm adds one edge each. The latency checks for R6 therefore use only zero-operand pairs and sample half a cycle after the second and the third edge. Every other result has a data-dependent latency. For those, a scoreboard records the expected value at the accepting edge and compares it when the output handshake is committed, which checks value and order but not timing. The back-pressure case fills the unit with widely spaced requests so that each one has settled before the queue depths are observed.

// File: rtl/gcd_pkg.sv
package gcd_pkg;
  localparam int GCD_OP_W      = 16;
  localparam int GCD_Q_DEPTH   = 2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CALC = 2'd1,
    ST_DONE = 2'd2
  } gcd_state_e;
endpackage

// File: rtl/gcd_fifo.sv
module gcd_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] data_o,
  output logic             empty_o,
  output logic             full_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_i) wr_ptr_q <= bump(wr_ptr_q);
      if (pop_i)  rd_ptr_q <= bump(rd_ptr_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_ptr_q] <= data_i;
  end

  assign data_o  = mem_q[rd_ptr_q];
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));

  // R3
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  // R3
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/gcd_step.sv
module gcd_step #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] a_o,
  output logic [W-1:0] b_o,
  output logic         done_o
);
  always_comb begin
    done_o = (b_i == '0);
    if (a_i < b_i) begin
      a_o = b_i;
      b_o = a_i;
    end else begin
      a_o = a_i - b_i;
      b_o = b_i;
    end
  end
endmodule

// File: rtl/gcd_core.sv
module gcd_core
  import gcd_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         req_avail_i,
  input  logic [W-1:0] req_a_i,
  input  logic [W-1:0] req_b_i,
  output logic         req_pop_o,
  input  logic         res_full_i,
  output logic         res_push_o,
  output logic [W-1:0] res_data_o
);
  gcd_state_e  state_q, state_d;
  logic [W-1:0] a_q, b_q, a_nxt, b_nxt;
  logic         step_done;

  gcd_step #(.W(W)) i_step (
    .a_i    (a_q),
    .b_i    (b_q),
    .a_o    (a_nxt),
    .b_o    (b_nxt),
    .done_o (step_done)
  );

  always_comb begin
    state_d    = state_q;
    req_pop_o  = 1'b0;
    res_push_o = 1'b0;
    case (state_q)
      ST_IDLE: if (req_avail_i && !res_full_i) begin
        req_pop_o = 1'b1;
        state_d   = ST_CALC;
      end
      ST_CALC: if (step_done) state_d = ST_DONE;
      ST_DONE: if (!res_full_i) begin
        res_push_o = 1'b1;
        state_d    = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      a_q     <= '0;
      b_q     <= '0;
    end else begin
      state_q <= state_d;
      if (req_pop_o) begin
        a_q <= req_a_i;
        b_q <= req_b_i;
      end else if (state_q == ST_CALC && !step_done) begin
        a_q <= a_nxt;
        b_q <= b_nxt;
      end
    end
  end

  assign res_data_o = a_q;

  // R4
  issue_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_pop_o |-> (req_avail_i && !res_full_i));
  // R4
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DONE && res_full_i) |=> (state_q == ST_DONE && $stable(a_q)));
  // R2
  zero_finish_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CALC && b_q == '0) |=> (state_q == ST_DONE));
  // R5
  single_flight_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_push_o |=> (state_q == ST_IDLE));
endmodule

// File: rtl/gcd_stream_unit.sv
module gcd_stream_unit
  import gcd_pkg::*;
#(
  parameter int OP_W    = GCD_OP_W,
  parameter int Q_DEPTH = GCD_Q_DEPTH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2*OP_W-1:0] in_data_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  output logic [OP_W-1:0]   out_data_o,
  output logic              out_valid_o,
  input  logic              out_ready_i
);
  localparam int REQ_W = 2 * OP_W;

  logic              in_push, in_pop, in_empty, in_full;
  logic [REQ_W-1:0]  in_head;
  logic              out_push, out_pop, out_empty, out_full;
  logic [OP_W-1:0]   core_res;

  assign in_ready_o = !in_full;
  assign in_push    = in_valid_i && !in_full;

  gcd_fifo #(.WIDTH(REQ_W), .DEPTH(Q_DEPTH)) i_req_q (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (in_push),
    .data_i  (in_data_i),
    .pop_i   (in_pop),
    .data_o  (in_head),
    .empty_o (in_empty),
    .full_o  (in_full)
  );

  gcd_core #(.W(OP_W)) i_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_avail_i (!in_empty),
    .req_a_i     (in_head[REQ_W-1:OP_W]),
    .req_b_i     (in_head[OP_W-1:0]),
    .req_pop_o   (in_pop),
    .res_full_i  (out_full),
    .res_push_o  (out_push),
    .res_data_o  (core_res)
  );

  gcd_fifo #(.WIDTH(OP_W), .DEPTH(Q_DEPTH)) i_res_q (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (out_push),
    .data_i  (core_res),
    .pop_i   (out_pop),
    .data_o  (out_data_o),
    .empty_o (out_empty),
    .full_o  (out_full)
  );

  assign out_valid_o = !out_empty;
  assign out_pop     = out_valid_o && out_ready_i;

  // R7
  resp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));
  // R3
  in_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_ready_o && !in_pop) |=> !in_ready_o);
endmodule

// File: tb/test_gcd_stream_unit.sv
module test_gcd_stream_unit;
  localparam int CLK_PERIOD = 10;
  localparam int OP_W       = 16;
  localparam int WDOG_CYC   = 190000;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic [2*OP_W-1:0] in_data = '0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [OP_W-1:0]   out_data;
  logic              out_valid;
  logic              out_ready = 1'b0;

  int checks = 0;
  int fails  = 0;
  int mode   = 0;   // 0: always ready, 1: random stall, 2: hold low
  int sent   = 0;
  int rcvd   = 0;
  logic [OP_W-1:0] sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  gcd_stream_unit i_gcd_stream_unit (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .in_data_i   (in_data),
    .in_valid_i  (in_valid),
    .in_ready_o  (in_ready),
    .out_data_o  (out_data),
    .out_valid_o (out_valid),
    .out_ready_i (out_ready)
  );

  function automatic logic [OP_W-1:0] ref_gcd(input logic [OP_W-1:0] x, input logic [OP_W-1:0] y);
    logic [OP_W-1:0] p = x, q = y, t;
    while (q != 0) begin
      t = p % q;
      p = q;
      q = t;
    end
    return p;
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // monitor: decide ready at negedge, score committed handshakes
  initial begin
    forever begin
      @(negedge clk);
      case (mode)
        0:       out_ready = 1'b1;
        1:       out_ready = 1'($urandom_range(0, 1));
        default: out_ready = 1'b0;
      endcase
      #1;
      if (rst_ni && out_valid && out_ready) begin
        if (sb.size() == 0) begin
          check(1'b0, "R5", "unexpected response", int'(out_data), -1);
        end else begin
          logic [OP_W-1:0] exp;
          exp = sb.pop_front();
          check(out_data == exp, "R1 R5", "response value", int'(out_data), int'(exp));
          rcvd++;
        end
      end
    end
  end

  initial begin
    repeat (WDOG_CYC) @(posedge clk);
    check(1'b0, "R5", "watchdog expired", 0, 1);
    finish_run();
  end

  task automatic send(input logic [OP_W-1:0] a, input logic [OP_W-1:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = {a, b};
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    sb.push_back(ref_gcd(a, b));
    sent++;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // accept on idle unit, then expect valid low after edge (lo_edges) and high one edge later
  task automatic latency_case(input logic [OP_W-1:0] a, input logic [OP_W-1:0] b, input int lo_edges);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = {a, b};
    sb.push_back(ref_gcd(a, b));
    sent++;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    repeat (lo_edges) @(posedge clk);
    @(negedge clk);
    #2;
    check(out_valid == 1'b0, "R6", "result too early", int'(out_valid), 0);
    @(posedge clk);
    @(negedge clk);
    #2;
    check(out_valid == 1'b1, "R6", "result due", int'(out_valid), 1);
    check(out_data == ref_gcd(a, b), "R6 R2", "result value", int'(out_data), int'(ref_gcd(a, b)));
  endtask

  initial begin
    // R8: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(in_ready == 1'b1, "R8", "in_ready in reset", int'(in_ready), 1);
    check(out_valid == 1'b0, "R8", "out_valid in reset", int'(out_valid), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "R8", "in_ready after reset", int'(in_ready), 1);
    check(out_valid == 1'b0, "R8", "out_valid after reset", int'(out_valid), 0);

    // R6: minimum latency, zero operand cases
    mode = 0;
    latency_case(16'd9, 16'd0, 2);
    drain();
    latency_case(16'd0, 16'd9, 3);
    drain();

    // R2: zero and small operands
    send(16'd0, 16'd0);
    send(16'd0, 16'd37);
    send(16'd123, 16'd0);
    drain();
    mode = 1;
    for (int i = 1; i <= 12; i++)
      for (int j = 1; j <= 12; j++) send(16'(i), 16'(j));
    drain();

    // R4 R3 R7: back-pressure capacity with consumer stalled
    mode = 2;
    repeat (3) @(negedge clk);
    send(16'd6, 16'd4);  repeat (20) @(negedge clk);
    send(16'd9, 16'd3);  repeat (20) @(negedge clk);
    send(16'd10, 16'd5); repeat (20) @(negedge clk);
    send(16'd8, 16'd12); repeat (20) @(negedge clk);
    #2;
    check(in_ready == 1'b0, "R4 R3", "in_ready after four requests", int'(in_ready), 0);
    check(out_valid == 1'b1, "R3", "out_valid with queued results", int'(out_valid), 1);
    check(out_data == 16'd2, "R7", "head result", int'(out_data), 2);
    // a fifth request must not be taken while in_ready is low
    in_valid = 1'b1;
    in_data  = {16'd7, 16'd7};
    repeat (6) @(negedge clk);
    in_valid = 1'b0;
    #2;
    check(out_valid == 1'b1, "R7", "out_valid held", int'(out_valid), 1);
    check(out_data == 16'd2, "R7", "head result held", int'(out_data), 2);
    check(in_ready == 1'b0, "R4", "in_ready still low", int'(in_ready), 0);
    mode = 1;
    drain();

    // R1 R5: random operands with random gaps and random stalls
    for (int k = 0; k < 60; k++) begin
      logic [OP_W-1:0] ra, rb;
      ra = 16'($urandom_range(256, 65535));
      rb = 16'($urandom_range(256, 65535));
      repeat ($urandom_range(0, 3)) @(negedge clk);
      send(ra, rb);
    end
    drain();

    // R1: boundary operands
    mode = 0;
    send(16'hFFFF, 16'hFFFF);
    send(16'd1, 16'hFFFF);
    send(16'hFFFF, 16'd1);
    drain();

    // R5: everything received exactly once
    check(rcvd == sent, "R5", "response count", rcvd, sent);
    repeat (10) @(negedge clk);
    check(out_valid == 1'b0, "R5", "no extra response", int'(out_valid), 0);
    check(in_ready == 1'b1, "R3", "in_ready when idle", int'(in_ready), 1);
    finish_run();
  end
endmodule